// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit evaluates one of sixteen ordering predicates on two IEEE-754 operands and stores the one-bit answer in a bank of eight condition flags. Each operand is a single, a double, or a pair of singles packed into one 64-bit word. A magnitude mode clears the sign bits of both operands before they are compared, so the predicate applies to absolute values.

A compare is issued by holding `in_valid` high for one clock together with the operands, the format, the predicate code, the magnitude select and the target flag index. At that clock edge the selected flag is set or cleared and the invalid-operation flag is refreshed. In paired mode the two lanes are evaluated in parallel and two adjacent flags are written. The flag bank is meant to feed branch and conditional-move logic elsewhere in the pipeline.

Top module: `fpcmp_unit`

## Requirements
- R1: The 4-bit predicate code is decoded by bits: bit 0 makes the result true when the operands are unordered, bit 1 when they are equal, and bit 2 when operand A is less than operand B. Code 0 is always false. A compare sets flag `cc_idx` when the result is true and clears it when the result is false.
- R2: A NaN operand (exponent all ones, mantissa non-zero) makes the pair unordered. Equal and less-than are then both false.
- R3: Positive zero and negative zero compare as equal, and neither is less than the other.
- R4: With `abs_mode` high, bit 31 of every single lane, or bit 63 of a double, is cleared in both operands before the compare. This applies to both lanes in paired mode.
- R5: Format code 0 (single) uses bits 31:0 of each operand. Bits 63:32 have no effect on the result or on the invalid flag.
- R6: Format code 1 (double) compares the full 64-bit operands.
- R7: Format code 2 (paired) compares bits 31:0 into flag `cc_idx` and bits 63:32 into flag (`cc_idx`+1) modulo 8, both in the same compare.
- R8: `invalid` is refreshed on every valid compare. It is set when any compared lane holds a signalling NaN (mantissa MSB 0). It is also set when predicate bit 3 is set and any compared lane holds a NaN of either kind. Otherwise it is cleared.
- R9: Flags that the compare does not target keep their value. Nothing changes while `in_valid` is low. A valid compare with the reserved format code 3 changes neither the bank nor `invalid`.
- R10: Synchronous reset clears all eight flags and `invalid`. Results appear on the outputs one clock after the valid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue a compare this cycle |
| op_a | input | 64 | Operand A (single and paired lanes packed from bit 0) |
| op_b | input | 64 | Operand B |
| fmt | input | 2 | 0 single, 1 double, 2 paired single, 3 reserved |
| pred | input | 4 | Predicate code |
| abs_mode | input | 1 | Compare magnitudes (sign bits cleared) |
| cc_idx | input | 3 | Target flag index (low lane in paired mode) |
| cc_bank | output | 8 | Registered condition flags |
| invalid | output | 1 | Registered invalid-operation flag of the last compare |

## Verification
On every cycle, the embedded assertions check several properties. Idle cycles and reserved-format compares leave the flags untouched. A single-format compare disturbs no other flag. The high lane of a paired compare lands on the wrapped neighbour index. No lane ever reports unordered together with equal or less. A signalling predicate on a NaN raises `invalid`. Reset clears the bank. The actual truth values of the sixteen predicates can only be shown by the bench's vector scenarios. The same holds for the zero and NaN corner cases, the effect of magnitude mode on negative operands, and the independence of single results from the upper operand bits.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_PAIR = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  // Relation of one lane pair, produced by a lane comparator.
  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
    logic nan;
    logic snan;
  } lane_flags_t;

  // Predicate bits 0..2 select which relations make the result true.
  function automatic logic pred_true(input logic [3:0] p, input lane_flags_t f);
    return (p[0] & f.unord) | (p[1] & f.eq) | (p[2] & f.lt);
  endfunction

  // Predicate bit 3 marks a signalling compare: any NaN is invalid.
  function automatic logic pred_invalid(input logic [3:0] p, input lane_flags_t f);
    return f.snan | (p[3] & f.nan);
  endfunction

endpackage

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  logic                 abs_mode,
  output lane_flags_t          flags
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int MAG_W = W - 1;

  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             nan_a, nan_b, snan_a, snan_b;
  logic             zero_a, zero_b;
  logic             unord, eq, lt, mag_lt, mag_gt;

  always_comb begin
    sign_a = a[W-1] & ~abs_mode;
    sign_b = b[W-1] & ~abs_mode;
    mag_a  = a[MAG_W-1:0];
    mag_b  = b[MAG_W-1:0];
    nan_a  = (&a[W-2:MAN_W]) & (|a[MAN_W-1:0]);
    nan_b  = (&b[W-2:MAN_W]) & (|b[MAN_W-1:0]);
    snan_a = nan_a & ~a[MAN_W-1];
    snan_b = nan_b & ~b[MAN_W-1];
    zero_a = (mag_a == '0);
    zero_b = (mag_b == '0);
    mag_lt = (mag_a < mag_b);
    mag_gt = (mag_b < mag_a);

    unord = nan_a | nan_b;
    eq    = ~unord & ((zero_a & zero_b) | ((sign_a == sign_b) & (mag_a == mag_b)));
    if (unord || eq)
      lt = 1'b0;
    else if (sign_a != sign_b)
      lt = sign_a;
    else if (sign_a)
      lt = mag_gt;
    else
      lt = mag_lt;

    flags.unord = unord;
    flags.eq    = eq;
    flags.lt    = lt;
    flags.nan   = unord;
    flags.snan  = snan_a | snan_b;
  end
endmodule

// File: rtl/fpcmp_cc_bank.sv
module fpcmp_cc_bank #(
  parameter int CC_N     = 8,
  parameter int CC_IDX_W = $clog2(CC_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic [CC_IDX_W-1:0] idx_lo,
  input  logic                val_lo,
  input  logic                wr_hi,
  input  logic [CC_IDX_W-1:0] idx_hi,
  input  logic                val_hi,
  output logic [CC_N-1:0]     bank
);
  for (genvar i = 0; i < CC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        bank[i] <= 1'b0;
      else if (wr_hi && (idx_hi == CC_IDX_W'(i)))
        bank[i] <= val_hi;
      else if (wr_lo && (idx_lo == CC_IDX_W'(i)))
        bank[i] <= val_lo;
    end
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23,
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  parameter int CC_N    = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [DBL_EXP+DBL_MAN:0]        op_a,
  input  logic [DBL_EXP+DBL_MAN:0]        op_b,
  input  logic [1:0]                      fmt,
  input  logic [3:0]                      pred,
  input  logic                            abs_mode,
  input  logic [$clog2(CC_N)-1:0]         cc_idx,
  output logic [CC_N-1:0]                 cc_bank,
  output logic                            invalid
);
  localparam int SGL_W    = 1 + SGL_EXP + SGL_MAN;
  localparam int DBL_W    = 1 + DBL_EXP + DBL_MAN;
  localparam int LANES    = DBL_W / SGL_W;
  localparam int CC_IDX_W = $clog2(CC_N);

  lane_flags_t d_fl;
  lane_flags_t s_fl [LANES];

  fpcmp_lane #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_dbl (
    .a(op_a), .b(op_b), .abs_mode(abs_mode), .flags(d_fl)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_sgl
    fpcmp_lane #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_sgl (
      .a(op_a[l*SGL_W +: SGL_W]),
      .b(op_b[l*SGL_W +: SGL_W]),
      .abs_mode(abs_mode),
      .flags(s_fl[l])
    );
  end

  lane_flags_t           lo_fl;
  logic                  res_lo, res_hi, inv_lo, inv_hi, inv_next;
  logic                  wr_lo, wr_hi;
  logic [CC_IDX_W-1:0]   idx_hi;

  always_comb begin
    lo_fl    = (fmt == FMT_DBL) ? d_fl : s_fl[0];
    res_lo   = pred_true(pred, lo_fl);
    res_hi   = pred_true(pred, s_fl[1]);
    inv_lo   = pred_invalid(pred, lo_fl);
    inv_hi   = pred_invalid(pred, s_fl[1]);
    wr_lo    = in_valid & (fmt != FMT_RSV);
    wr_hi    = in_valid & (fmt == FMT_PAIR);
    idx_hi   = cc_idx + CC_IDX_W'(1);
    inv_next = inv_lo | ((fmt == FMT_PAIR) & inv_hi);
  end

  fpcmp_cc_bank #(.CC_N(CC_N)) u_bank (
    .clk(clk), .rst(rst),
    .wr_lo(wr_lo), .idx_lo(cc_idx), .val_lo(res_lo),
    .wr_hi(wr_hi), .idx_hi(idx_hi), .val_hi(res_hi),
    .bank(cc_bank)
  );

  always_ff @(posedge clk) begin
    if (rst)
      invalid <= 1'b0;
    else if (wr_lo)
      invalid <= inv_next;
  end

  // R10: reset empties the bank
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (cc_bank == '0) && !invalid);

  // R9: idle cycles hold state
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cc_bank) && $stable(invalid));

  // R9: reserved format touches nothing
  assert_reserved_fmt_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == FMT_RSV) |=> $stable(cc_bank) && $stable(invalid));

  // R1: a single-format compare changes at most its own flag
  assert_single_target_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == FMT_SGL) |=>
      (((cc_bank ^ $past(cc_bank)) & ~(CC_N'(1) << $past(cc_idx))) == '0));

  // R7: high lane result lands on the wrapped neighbour flag
  assert_pair_high_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == FMT_PAIR) |=> (cc_bank[$past(idx_hi)] == $past(res_hi)));

  // R2: unordered excludes equal and less in every lane
  assert_unord_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(d_fl.unord && (d_fl.eq || d_fl.lt)) &&
    !(s_fl[0].unord && (s_fl[0].eq || s_fl[0].lt)) &&
    !(s_fl[1].unord && (s_fl[1].eq || s_fl[1].lt)));

  // R8: signalling predicate on a NaN raises invalid
  assert_sig_nan_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == FMT_SGL && pred[3] && s_fl[0].nan) |=> invalid);

endmodule

// File: tb/fpcmp_unit_test.sv
`timescale 1ns/1ps
module fpcmp_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  fmt = 2'd0;
  logic [3:0]  pred = 4'd0;
  logic        abs_mode = 1'b0;
  logic [2:0]  cc_idx = 3'd0;
  logic [7:0]  cc_bank;
  logic        invalid;

  always #2.5 clk = ~clk;

  fpcmp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .fmt(fmt), .pred(pred), .abs_mode(abs_mode), .cc_idx(cc_idx),
    .cc_bank(cc_bank), .invalid(invalid)
  );

  typedef struct packed {
    logic [1:0]  f;
    logic [3:0]  p;
    logic        ab;
    logic [2:0]  cc;
    logic [63:0] a;
    logic [63:0] b;
    logic        lo;
    logic        hi;
    logic        inv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd2,  1'b0, 3'd0, 64'h00000000_3F800000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b0}, // R1 eq
    '{2'd0, 4'd4,  1'b0, 3'd1, 64'h00000000_3F800000, 64'h00000000_40000000, 1'b1, 1'b0, 1'b0}, // R1 olt true
    '{2'd0, 4'd4,  1'b0, 3'd2, 64'h00000000_40000000, 64'h00000000_3F800000, 1'b0, 1'b0, 1'b0}, // R1 olt false
    '{2'd0, 4'd6,  1'b0, 3'd2, 64'h00000000_C0000000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b0}, // R1 ole negative
    '{2'd0, 4'd4,  1'b1, 3'd2, 64'h00000000_C0000000, 64'h00000000_3F800000, 1'b0, 1'b0, 1'b0}, // R4 magnitude
    '{2'd0, 4'd2,  1'b0, 3'd3, 64'h00000000_00000000, 64'h00000000_80000000, 1'b1, 1'b0, 1'b0}, // R3 zeros
    '{2'd0, 4'd1,  1'b0, 3'd4, 64'h00000000_7FC00000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b0}, // R2 qnan un
    '{2'd0, 4'd3,  1'b0, 3'd5, 64'h00000000_7FA00000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b1}, // R8 snan
    '{2'd0, 4'd12, 1'b0, 3'd0, 64'h00000000_7FC00000, 64'h00000000_3F800000, 1'b0, 1'b0, 1'b1}, // R2 R8 lt
    '{2'd0, 4'd15, 1'b0, 3'd6, 64'h00000000_7FC00000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b1}, // R8 ngt
    '{2'd0, 4'd0,  1'b0, 3'd1, 64'h00000000_3F800000, 64'h00000000_3F800000, 1'b0, 1'b0, 1'b0}, // R1 false
    '{2'd1, 4'd4,  1'b0, 3'd7, 64'hC000000000000000,  64'h3FF0000000000000,  1'b1, 1'b0, 1'b0}, // R6 olt
    '{2'd1, 4'd4,  1'b1, 3'd7, 64'hC000000000000000,  64'h3FF0000000000000,  1'b0, 1'b0, 1'b0}, // R4 double
    '{2'd1, 4'd10, 1'b0, 3'd0, 64'h7FF8000000000000,  64'h7FF8000000000000,  1'b0, 1'b0, 1'b1}, // R6 seq nan
    '{2'd2, 4'd6,  1'b0, 3'd2, 64'h40000000_3F800000, 64'h3F800000_3F800000, 1'b1, 1'b0, 1'b0}, // R7 ole
    '{2'd2, 4'd12, 1'b1, 3'd4, 64'hBF800000_C0000000, 64'h40000000_3F800000, 1'b0, 1'b1, 1'b0}, // R4 R7 abs
    '{2'd1, 4'd6,  1'b0, 3'd1, 64'h8000000000000000,  64'h0000000000000000,  1'b1, 1'b0, 1'b0}, // R3 double
    '{2'd0, 4'd2,  1'b0, 3'd6, 64'hFFFFFFFF_3F800000, 64'h00000000_3F800000, 1'b1, 1'b0, 1'b0}, // R5 upper
    '{2'd2, 4'd2,  1'b0, 3'd7, 64'h3F800000_3F800000, 64'h3F800000_40000000, 1'b0, 1'b1, 1'b0}, // R7 wrap
    '{2'd2, 4'd1,  1'b0, 3'd0, 64'h7FA00000_3F800000, 64'h3F800000_3F800000, 1'b0, 1'b1, 1'b1}  // R8 hi lane
  };

  int         n_chk = 0, n_fail = 0;
  logic [7:0] model = '0;
  logic       finished = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] f, input logic [3:0] p, input logic ab,
                       input logic [2:0] cc, input logic [63:0] a, input logic [63:0] b,
                       input logic v);
    fmt = f; pred = p; abs_mode = ab; cc_idx = cc; op_a = a; op_b = b; in_valid = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset bank", cc_bank, 8'h00);
    check("R10 reset invalid", {7'b0, invalid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].f, VECS[i].p, VECS[i].ab, VECS[i].cc, VECS[i].a, VECS[i].b, 1'b1);
      model[VECS[i].cc] = VECS[i].lo;
      if (VECS[i].f == 2'd2) model[VECS[i].cc + 3'd1] = VECS[i].hi;
      check($sformatf("R1 vector %0d bank", i), cc_bank, model);
      check($sformatf("R8 vector %0d invalid", i), {7'b0, invalid}, {7'b0, VECS[i].inv});
    end

    // R9: idle cycles with changing inputs
    for (int k = 0; k < 3; k++)
      issue(2'd0, 4'd15, 1'b0, 3'(k), 64'h7FA00000_7FA00000, 64'h0, 1'b0);
    check("R9 idle bank", cc_bank, model);
    check("R9 idle invalid", {7'b0, invalid}, 8'h01);

    // R9: reserved format with valid
    issue(2'd3, 4'd1, 1'b0, 3'd2, 64'h00000000_7FC00000, 64'h0, 1'b1);
    check("R9 reserved bank", cc_bank, model);
    check("R9 reserved invalid", {7'b0, invalid}, 8'h01);

    // R8: clean compare clears invalid; R5 upper sNaN bits ignored
    issue(2'd0, 4'd7, 1'b0, 3'd3, 64'h7FA00000_3F800000, 64'h7FA00000_40000000, 1'b1);
    model[3] = 1'b1;
    check("R5 R8 clean compare invalid", {7'b0, invalid}, 8'h00);
    check("R5 clean compare bank", cc_bank, model);

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R10 mid-run bank", cc_bank, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule